// File: doc/BRIEF.md
# Chunked Thread-Block Dispatcher with Neighbour Stealing

This block hands out thread-block IDs to a fixed group of compute units (CUs) over a series of kernel launches. At each launch the linear ID range `0 .. grid_size-1` is cut into contiguous slices, one per CU. Every slice is loaded into that CU's private entry in the launch cycle, before any block is issued. Each entry holds the lowest remaining ID and an exclusive upper bound. A CU asks for its next block by raising its `req` bit. If it has work, the grant and the ID come back combinationally in the same cycle, and the entry advances at the next clock edge.

A two-bit mode chosen at launch selects the policy for the kernel:

- **Rotating chunk:** the first slice goes to a CU that moves on by one with every launch in this mode.
- **Fixed origin:** the first slice always goes to CU 0, so a given ID lands on the same CU in every kernel.
- **Alternating direction:** uses the fixed origin and reverses the issue order inside each slice on alternate kernels. The blocks that ran last in one kernel then run first in the next, while their data is likely still in the local cache.
- **Steal:** uses the fixed origin and ascending issue. A requesting CU whose own slice is spent takes the highest remaining ID from a neighbour's slice. It parks that ID in a one-entry steal queue and issues it from there.

Top module: `tbs_scheduler`

## Requirements
- R1: At launch, the slice at position p (p = 0 .. NUM_CU-1) covers IDs starting at p*B + min(p,M), with size B+1 for p < M and B otherwise. Here B = grid_size / NUM_CU and M = grid_size % NUM_CU, so the leftover blocks go one each to the lowest positions.
- R2: While a CU has IDs left in its slice and `req` is high, `grant` is high in that same cycle. In ascending order `grant_id` is the lowest remaining ID, and the entry advances at the next edge.
- R3: In mode 0 (rotating chunk), position p goes to CU (r+p) mod NUM_CU. Here r is 0 after reset and moves up by one (mod NUM_CU) with each mode-0 launch. Launches in other modes leave r unchanged.
- R4: In modes 1, 2 and 3, position p always goes to CU p, so an ID maps to the same CU in every such kernel.
- R5: In mode 2 (alternating direction), the first mode-2 kernel after reset, or after a launch in any other mode, issues in ascending order. Each further consecutive mode-2 kernel flips the order. In descending order `grant_id` is the highest remaining ID.
- R6: In mode 3 (steal), a requesting CU whose slice and steal queue are both empty captures the victim's highest remaining ID into its queue at the next edge. That ID is granted in the following cycle while `req` stays high.
- R7: A thief looks for a victim in this order: its left neighbour (index-1 mod NUM_CU), then its right neighbour (index+1 mod NUM_CU), then the other CUs in ascending index order.
- R8: When several thieves pick the same victim in one cycle, only the lowest-indexed thief takes a block. A CU with exactly one ID left that is issuing it in the same cycle cannot be stolen from.
- R9: In modes 0, 1 and 2 no block ever moves between CUs: a requesting CU with an empty slice gets no grant. `idle[i]` is high exactly when CU i has no slice IDs and no queued ID.
- R10: After reset every `idle` bit and `kernel_done` are high and no grant is given. `kernel_done` is low after a launch with a non-zero grid and returns high once every slice and queue is empty.
- R11: Within one kernel every ID below `grid_size` is granted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | One-cycle pulse that starts a kernel; no grant in that cycle |
| grid_size | input | ID_W | Number of thread blocks in the kernel, sampled with `launch` |
| mode | input | 2 | Policy: 0 rotating chunk, 1 fixed origin, 2 alternating direction, 3 steal |
| req | input | NUM_CU | Per-CU request for the next block |
| grant | output | NUM_CU | Per-CU grant, same cycle as the request |
| grant_id | output | NUM_CU*ID_W | Granted ID, CU i in bits [i*ID_W +: ID_W] |
| idle | output | NUM_CU | CU has neither slice IDs nor a queued ID |
| kernel_done | output | 1 | All slices and steal queues are empty |

## Verification
The in-line properties watch, on every cycle, the local invariants of the dispatcher:

- an entry never issues from an empty slice;
- its lower bound never passes its upper bound;
- an owner issue and a steal on the same entry happen only when two or more IDs remain;
- each steal fills exactly one queue, and a filled queue is valid at the next edge;
- no grant appears while `kernel_done` is high.

Several behaviours only show up in the directed scenarios, because they depend on the sequence of IDs a CU receives:

- which CU receives which slice and the remainder placement;
- the rotation across launches;
- the alternating direction across kernels;
- the left-right-scan victim order;
- the lowest-index win under contention;
- exactly-once coverage of the grid.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [1:0] {
    MODE_CHUNK = 2'd0,
    MODE_FIXED = 2'd1,
    MODE_ALT   = 2'd2,
    MODE_STEAL = 2'd3
  } sched_mode_e;
endpackage

// File: rtl/tbs_chunk_calc.sv
// Computes the slice bounds of every CU for the grid being launched.
module tbs_chunk_calc #(
  parameter int NUM_CU = 4,
  parameter int ID_W   = 8,
  parameter int CU_W   = 2
) (
  input  logic [ID_W-1:0]                 grid_size,
  input  logic [CU_W-1:0]                 first_cu,
  output logic [NUM_CU-1:0][ID_W-1:0]     lo_o,
  output logic [NUM_CU-1:0][ID_W-1:0]     hi_o
);
  logic [ID_W-1:0] base;
  logic [ID_W-1:0] extra;

  assign base  = grid_size / ID_W'(NUM_CU);
  assign extra = grid_size % ID_W'(NUM_CU);

  for (genvar c = 0; c < NUM_CU; c++) begin : g_slice
    int              pos;
    logic [ID_W-1:0] start_v;
    logic [ID_W-1:0] size_v;
    // position of this CU in the distribution order
    assign pos     = (c + NUM_CU - int'(first_cu)) % NUM_CU;
    assign start_v = ID_W'(pos * int'(base) + ((pos < int'(extra)) ? pos : int'(extra)));
    assign size_v  = base + ((pos < int'(extra)) ? ID_W'(1) : ID_W'(0));
    assign lo_o[c] = start_v;
    assign hi_o[c] = start_v + size_v;
  end
endmodule

// File: rtl/tbs_cu_entry.sv
// Per-CU slice entry [lo, hi) plus one-deep steal queue.
module tbs_cu_entry #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ID_W-1:0] load_lo,
  input  logic [ID_W-1:0] load_hi,
  input  logic            issue,
  input  logic            dir_down,
  input  logic            steal_dec,
  input  logic            q_fill,
  input  logic [ID_W-1:0] q_fill_id,
  input  logic            q_pop,
  output logic [ID_W-1:0] lo_q,
  output logic [ID_W-1:0] hi_q,
  output logic            q_valid,
  output logic [ID_W-1:0] q_id
);
  logic [ID_W-1:0] lo_d, hi_d;
  logic            qv_d;
  logic            ent_en, q_en;

  assign ent_en = load | issue | steal_dec;
  assign q_en   = load | q_fill | q_pop;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (load) begin
      lo_d = load_lo;
      hi_d = load_hi;
    end else begin
      if (issue && !dir_down) lo_d = lo_q + 1'b1;
      if ((issue && dir_down) || steal_dec) hi_d = hi_q - 1'b1;
    end
  end

  always_comb begin
    qv_d = q_valid;
    if (load)        qv_d = 1'b0;
    else if (q_fill) qv_d = 1'b1;
    else if (q_pop)  qv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ent_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else if (q_en) begin
      q_valid <= qv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_id <= '0;
    end else if (q_fill && !load) begin
      q_id <= q_fill_id;
    end
  end

  assert_issue_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (lo_q < hi_q));
  assert_bounds_ordered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q <= hi_q);
  assert_no_double_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && steal_dec) |-> ((hi_q - lo_q) >= ID_W'(2)));
  assert_fill_when_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_fill |-> (!q_valid && (lo_q == hi_q)));
  assert_pop_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> q_valid);
  assert_steal_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    steal_dec |-> !dir_down);
endmodule

// File: rtl/tbs_steal_arb.sv
// Victim search (left, right, ascending scan) and per-victim fixed priority.
module tbs_steal_arb #(
  parameter int NUM_CU = 4,
  parameter int CU_W   = 2
) (
  input  logic [NUM_CU-1:0]           want,
  input  logic [NUM_CU-1:0]           elig,
  output logic [NUM_CU-1:0]           win,
  output logic [NUM_CU-1:0]           dec,
  output logic [NUM_CU-1:0][CU_W-1:0] vic
);
  logic [NUM_CU-1:0][NUM_CU-1:0] tgt;

  always_comb begin : p_target
    logic hit;
    tgt = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM_CU; i++) begin
      hit = 1'b0;
      if (want[i]) begin
        if (elig[(i + NUM_CU - 1) % NUM_CU]) begin
          tgt[i][(i + NUM_CU - 1) % NUM_CU] = 1'b1;
        end else if (elig[(i + 1) % NUM_CU]) begin
          tgt[i][(i + 1) % NUM_CU] = 1'b1;
        end else begin
          for (int j = 0; j < NUM_CU; j++) begin
            if (!hit && (j != i) && elig[j]) begin
              tgt[i][j] = 1'b1;
              hit       = 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin : p_grant
    win = '0;
    dec = '0;
    vic = '0;
    for (int j = 0; j < NUM_CU; j++) begin
      for (int i = 0; i < NUM_CU; i++) begin
        if (tgt[i][j] && !dec[j]) begin
          win[i] = 1'b1;
          dec[j] = 1'b1;
          vic[i] = CU_W'(j);
        end
      end
    end
  end
endmodule

// File: rtl/tbs_scheduler.sv
module tbs_scheduler
  import tbs_pkg::*;
#(
  parameter int NUM_CU = 4,
  parameter int ID_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch,
  input  logic [ID_W-1:0]        grid_size,
  input  logic [1:0]             mode,
  input  logic [NUM_CU-1:0]      req,
  output logic [NUM_CU-1:0]      grant,
  output logic [NUM_CU*ID_W-1:0] grant_id,
  output logic [NUM_CU-1:0]      idle,
  output logic                   kernel_done
);
  localparam int CU_W = (NUM_CU > 1) ? $clog2(NUM_CU) : 1;

  sched_mode_e     mode_q, mode_d, mode_in;
  logic            dir_q, dir_d;
  logic            alt_q, alt_d;
  logic [CU_W-1:0] rot_q, rot_d, first_cu;
  logic            is_steal;

  assign mode_in  = sched_mode_e'(mode);
  assign first_cu = (mode_in == MODE_CHUNK) ? rot_q : '0;
  assign is_steal = (mode_q == MODE_STEAL);

  // kernel-level next state, applied only on launch
  always_comb begin
    mode_d = mode_in;
    dir_d  = (mode_in == MODE_ALT) ? alt_q : 1'b0;
    alt_d  = (mode_in == MODE_ALT) ? ~alt_q : 1'b0;
    rot_d  = rot_q;
    if (mode_in == MODE_CHUNK) begin
      rot_d = (rot_q == CU_W'(NUM_CU - 1)) ? '0 : rot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CHUNK;
      dir_q  <= 1'b0;
      alt_q  <= 1'b0;
      rot_q  <= '0;
    end else if (launch) begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      alt_q  <= alt_d;
      rot_q  <= rot_d;
    end
  end

  logic [NUM_CU-1:0][ID_W-1:0] ld_lo, ld_hi, lo_q, hi_q, q_id, q_fill_id;
  logic [NUM_CU-1:0]           q_valid, has_chunk, grant_chunk, grant_q;
  logic [NUM_CU-1:0]           want, elig, q_fill, steal_dec;
  logic [NUM_CU-1:0][CU_W-1:0] vic;

  tbs_chunk_calc #(.NUM_CU(NUM_CU), .ID_W(ID_W), .CU_W(CU_W)) u_calc (
    .grid_size (grid_size),
    .first_cu  (first_cu),
    .lo_o      (ld_lo),
    .hi_o      (ld_hi)
  );

  tbs_steal_arb #(.NUM_CU(NUM_CU), .CU_W(CU_W)) u_arb (
    .want (want),
    .elig (elig),
    .win  (q_fill),
    .dec  (steal_dec),
    .vic  (vic)
  );

  for (genvar c = 0; c < NUM_CU; c++) begin : g_cu
    logic [ID_W-1:0] left_cnt;

    assign left_cnt       = hi_q[c] - lo_q[c];
    assign has_chunk[c]   = (left_cnt != '0);
    assign grant_chunk[c] = req[c] & has_chunk[c] & ~launch;
    assign grant_q[c]     = req[c] & ~has_chunk[c] & q_valid[c] & ~launch;
    assign grant[c]       = grant_chunk[c] | grant_q[c];
    assign grant_id[c*ID_W +: ID_W] = grant_chunk[c] ? (dir_q ? hi_q[c] - 1'b1 : lo_q[c])
                                                     : q_id[c];
    assign idle[c]        = ~has_chunk[c] & ~q_valid[c];
    assign want[c]        = is_steal & req[c] & ~has_chunk[c] & ~q_valid[c] & ~launch;
    assign elig[c]        = is_steal & ~launch &
                            ((left_cnt >= ID_W'(2)) | ((left_cnt == ID_W'(1)) & ~grant_chunk[c]));
    assign q_fill_id[c]   = hi_q[vic[c]] - 1'b1;

    tbs_cu_entry #(.ID_W(ID_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (launch),
      .load_lo   (ld_lo[c]),
      .load_hi   (ld_hi[c]),
      .issue     (grant_chunk[c]),
      .dir_down  (dir_q),
      .steal_dec (steal_dec[c]),
      .q_fill    (q_fill[c]),
      .q_fill_id (q_fill_id[c]),
      .q_pop     (grant_q[c]),
      .lo_q      (lo_q[c]),
      .hi_q      (hi_q[c]),
      .q_valid   (q_valid[c]),
      .q_id      (q_id[c])
    );

    assert_queue_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      q_fill[c] |=> q_valid[c]);
  end

  assign kernel_done = &idle;

  assert_steal_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_fill) == $countones(steal_dec));
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_done |-> (grant == '0));
  assert_steal_mode_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (steal_dec != '0) |-> (mode_q == MODE_STEAL));
endmodule

// File: tb/tb_tbs_scheduler.sv
`timescale 1ns/1ps
module tb_tbs_scheduler;
  localparam int N  = 4;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          launch;
  logic [IW-1:0] grid_size;
  logic [1:0]    mode;
  logic [N-1:0]  req;
  logic [N-1:0]  grant;
  logic [N*IW-1:0] grant_id;
  logic [N-1:0]  idle;
  logic          kernel_done;

  tbs_scheduler #(.NUM_CU(N), .ID_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .launch(launch), .grid_size(grid_size), .mode(mode),
    .req(req), .grant(grant), .grant_id(grant_id), .idle(idle), .kernel_done(kernel_done)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int seq  [N][64];
  int gcyc [N][64];
  int cnt  [N];
  bit seen [256];
  int dups;
  int exp_rot = 0;
  int cur_first;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int u = 0; u < N; u++) cnt[u] = 0;
    for (int k = 0; k < 256; k++) seen[k] = 1'b0;
    dups = 0;
  endtask

  task automatic do_launch(input int g, input int m);
    clear_log();
    @(negedge clk);
    req = '0; launch = 1'b1; grid_size = IW'(g); mode = 2'(m);
    cur_first = (m == 0) ? exp_rot : 0;
    if (m == 0) exp_rot = (exp_rot + 1) % N;
    @(negedge clk);
    launch = 1'b0;
    #1;
    if (g != 0) chk(kernel_done == 1'b0, "R10 busy after launch", kernel_done, 0);
  endtask

  task automatic run(input int cycles, input logic [N-1:0] mask);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      req = mask;
      #1;
      for (int u = 0; u < N; u++) begin
        if (grant[u]) begin
          int id;
          id = int'(grant_id[u*IW +: IW]);
          if (cnt[u] < 64) begin
            seq[u][cnt[u]]  = id;
            gcyc[u][cnt[u]] = c;
            cnt[u]++;
          end
          if (seen[id]) dups++;
          seen[id] = 1'b1;
        end
      end
    end
    @(negedge clk);
    req = '0;
  endtask

  function automatic int slice_lo(input int g, input int p);
    int b, m;
    b = g / N; m = g % N;
    return p * b + ((p < m) ? p : m);
  endfunction

  function automatic int slice_sz(input int g, input int p);
    return g / N + ((p < g % N) ? 1 : 0);
  endfunction

  task automatic expect_slice(input int cu, input int lo, input int sz, input bit down,
                              input string r);
    chk(cnt[cu] == sz, r, cnt[cu], sz);
    for (int k = 0; k < sz && k < cnt[cu]; k++) begin
      int e;
      e = down ? (lo + sz - 1 - k) : (lo + k);
      chk(seq[cu][k] == e, r, seq[cu][k], e);
    end
  endtask

  task automatic expect_cover(input int g, input string r);
    int n;
    n = 0;
    for (int k = 0; k < g; k++) if (seen[k]) n++;
    chk(n == g, r, n, g);
    chk(dups == 0, r, dups, 0);
    chk(kernel_done == 1'b1, "R10 done after drain", kernel_done, 1);
  endtask

  task automatic t_reset_state();
    req = '1;
    #1;
    chk(idle == '1, "R10 reset idle", int'(idle), 15);
    chk(kernel_done == 1'b1, "R10 reset done", kernel_done, 1);
    chk(grant == '0, "R10 reset no grant", int'(grant), 0);
    req = '0;
  endtask

  task automatic t_fixed_even();
    do_launch(24, 1);
    run(10, 4'hF);
    for (int c = 0; c < N; c++) expect_slice(c, c * 6, 6, 1'b0, "R2 R4 fixed 24");
    expect_cover(24, "R11 cover 24");
  endtask

  task automatic t_remainder();
    do_launch(10, 1);
    run(6, 4'hF);
    for (int c = 0; c < N; c++)
      expect_slice(c, slice_lo(10, c), slice_sz(10, c), 1'b0, "R1 remainder 10");
    expect_cover(10, "R11 cover 10");
  endtask

  task automatic t_chunk_rotate();
    for (int k = 0; k < 4; k++) begin
      int m;
      m = (k == 2) ? 1 : 0;
      do_launch(11, m);
      run(6, 4'hF);
      for (int p = 0; p < N; p++)
        expect_slice((cur_first + p) % N, slice_lo(11, p), slice_sz(11, p), 1'b0,
                     "R3 rotation");
      expect_cover(11, "R11 cover rotate");
    end
  endtask

  task automatic t_alternate();
    bit pat [5] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    int md  [5] = '{2, 2, 2, 1, 2};
    for (int k = 0; k < 5; k++) begin
      do_launch(8, md[k]);
      run(4, 4'hF);
      for (int c = 0; c < N; c++) expect_slice(c, 2 * c, 2, pat[k], "R5 alternate");
      expect_cover(8, "R11 cover alt");
    end
  endtask

  task automatic t_no_steal();
    do_launch(8, 1);
    run(10, 4'b0010);
    expect_slice(1, 2, 2, 1'b0, "R9 no steal");
    chk(idle == 4'b0010, "R9 idle map", int'(idle), 2);
    run(4, 4'hF);
    expect_cover(8, "R11 cover no steal");
  endtask

  task automatic t_steal_order();
    int e [8] = '{2, 3, 1, 0, 5, 4, 7, 6};
    do_launch(8, 3);
    run(20, 4'b0010);
    chk(cnt[1] == 8, "R7 steal count", cnt[1], 8);
    for (int k = 0; k < 8; k++) chk(seq[1][k] == e[k], "R7 victim order", seq[1][k], e[k]);
    chk(gcyc[1][2] == 3, "R6 steal latency", gcyc[1][2], 3);
    expect_cover(8, "R11 cover steal");
  endtask

  task automatic t_steal_contend();
    do_launch(4, 3);
    run(1, 4'b1101);
    run(6, 4'b0101);
    chk(cnt[0] == 2, "R8 winner count", cnt[0], 2);
    chk(seq[0][1] == 1, "R8 winner id", seq[0][1], 1);
    chk(gcyc[0][1] == 1, "R6 queued grant", gcyc[0][1], 1);
    chk(cnt[2] == 1, "R8 loser count", cnt[2], 1);
    expect_cover(4, "R11 cover contend");
  endtask

  task automatic t_steal_same_cycle();
    do_launch(4, 3);
    run(1, 4'b1101);
    run(6, 4'b0110);
    chk(cnt[1] == 1 && seq[1][0] == 1, "R8 owner keeps last", seq[1][0], 1);
    chk(cnt[2] == 1, "R8 no steal of issuing block", cnt[2], 1);
    expect_cover(4, "R11 cover same cycle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; launch = 1'b0; grid_size = '0; mode = '0; req = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_fixed_even();
    t_remainder();
    t_chunk_rotate();
    t_alternate();
    t_no_steal();
    t_steal_order();
    t_steal_contend();
    t_steal_same_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule